// File: doc/BRIEF.md
# Expansion Card Bus-Master Handshake Controller

This controller sits on an expansion card and lets the card borrow the system bus of a 6502-style processor, but only with the processor's consent. When the card has work, it pulls the interrupt line low. The service routine selects whatever memory banks the transfer needs, programs a beat count, and writes any byte to a trigger register. That write is the processor's consent. The card then waits for the processor's next opcode fetch (SYNC high). It halts the processor by pulling the ready line low and floats the processor off the bus by driving bus-enable low. It runs a fixed number of bus beats and hands the bus back. It then publishes a result byte, which the service routine reads before it returns.

The card never writes bank-select state. Banking is the processor's job, done before the trigger. A vector pull or a host reset that arrives after the trigger but before the SYNC boundary means the processor has left the service routine's controlled path. In that case the card gives up the transfer without touching the bus and reports an abort. The transfer engine is a beat counter with a strobe and a beat index, ready for a real data path to hang off it.

The state sequence is IDLE → REQ_IRQ (interrupt pending) → ARMED (one setup cycle after the trigger) → WAIT_SYNC → MASTER (beats) → RELEASE (bus returned, processor still halted) → DONE (result visible). The named transitions are:
- request: IDLE to REQ_IRQ on `svc_req`.
- trigger: REQ_IRQ to ARMED.
- proceed: ARMED to WAIT_SYNC.
- empty: ARMED to DONE when the count is zero.
- abort: ARMED or WAIT_SYNC to DONE on a vector pull or host reset.
- grab: WAIT_SYNC to MASTER on SYNC.
- last-beat: MASTER to RELEASE.
- finish: RELEASE to DONE.
- acknowledge: DONE to IDLE on a status read.

Top module: `card_busmaster_ctl`

## Requirements
- R1: After reset, `irq_n`, `rdy` and `be` are all 1. The status register reads 0x00 and the count register reads 0x00.
- R2: A `svc_req` pulse while IDLE drives `irq_n` to 0 on the next cycle. `irq_n` stays at 0 until a trigger is accepted.
- R3: The register map is as follows. A write to address 0 sets the 8-bit beat count, and a read of address 0 returns it. A write of any byte to address 1 is the trigger. A read of address 2 returns the status. `reg_rdata` is combinational on `reg_addr`.
- R4: A trigger written while the interrupt is pending is accepted. On the following cycle `irq_n` is 1 and the status reads 0x00, meaning busy.
- R5: After the trigger, `be` and `rdy` stay at 1 until SYNC is sampled high in WAIT_SYNC. A SYNC in the single cycle right after the trigger (ARMED) is ignored.
- R6: On the cycle after SYNC is taken, `rdy` and `be` are both 0. `xfer_beat` is then 1 for exactly count cycles, with `beat_num` running 0, 1, … count−1.
- R7: After the last beat, `be` returns to 1 one cycle before `rdy` returns to 1. For a count N > 0, `rdy` is low for N+1 cycles.
- R8: A vector pull (`cpu_vp_n` = 0) or `host_reset` = 1 in ARMED or WAIT_SYNC ends the transfer without taking the bus, and the status becomes 0x80. An abort wins over a SYNC in the same cycle.
- R9: A completed transfer sets the status to 0x01 in the cycle `rdy` returns to 1.
- R10: A count of 0 completes with status 0x01 and never lowers `rdy` or `be`.
- R11: A status read (`reg_rd` with address 2) in DONE returns the controller to IDLE, so a new request can follow. The status value holds until the next accepted trigger.
- R12: A trigger write when no interrupt is pending is ignored. `irq_n`, `rdy` and `be` stay at 1, SYNC pulses are ignored, and the status is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Active-low reset of the controller |
| svc_req | input | 1 | Card logic asks for a transfer |
| reg_wr | input | 1 | Register write strobe from the processor |
| reg_rd | input | 1 | Register read strobe from the processor |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| cpu_sync | input | 1 | Processor opcode-fetch indicator |
| cpu_vp_n | input | 1 | Processor vector pull, active low |
| host_reset | input | 1 | System reset seen on the bus, active high |
| irq_n | output | 1 | Interrupt request to the processor, active low |
| rdy | output | 1 | Ready line to the processor, 0 halts it |
| be | output | 1 | Bus enable for the processor, 0 floats it |
| xfer_beat | output | 1 | One bus beat of the transfer this cycle |
| beat_num | output | 8 | Index of the current beat |

## Verification
A wrong state shows at the ports within one cycle, because `irq_n`, `rdy`, `be` and the status byte are all decoded directly from the state register:
- A controller stuck in REQ_IRQ leaves `irq_n` low after the trigger.
- A premature grab lowers `be` with no SYNC the cycle before.
- A skipped RELEASE makes `rdy` and `be` rise together.

A miscounting beat counter shows as a wrong beat count or a wrong `rdy`-low length per transfer. A bad abort path shows as a bus grab or as a status other than 0x80 on the cycle after the vector pull.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_REQ_IRQ, ST_ARMED, ST_WAIT_SYNC, ST_MASTER, ST_RELEASE, ST_DONE
    } cbm_state_e;

    localparam int unsigned REG_AW = 2;
    localparam logic [REG_AW-1:0] A_COUNT   = 2'd0;
    localparam logic [REG_AW-1:0] A_TRIGGER = 2'd1;
    localparam logic [REG_AW-1:0] A_STATUS  = 2'd2;

    localparam logic [7:0] ST_CODE_BUSY  = 8'h00;
    localparam logic [7:0] ST_CODE_OK    = 8'h01;
    localparam logic [7:0] ST_CODE_ABORT = 8'h80;
endpackage

// File: rtl/cbm_regs.sv
module cbm_regs
    import cbm_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              trig_take,
    input  logic              fin_ok,
    input  logic              fin_abort,
    output logic              trig_wr,
    output logic [CNT_W-1:0]  count_q,
    output logic [7:0]        status_q,
    output logic [7:0]        rd_data
);
    logic [7:0] count_ext;

    assign trig_wr = reg_wr && (reg_addr == A_TRIGGER);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (reg_wr && reg_addr == A_COUNT) begin
            count_q <= CNT_W'(reg_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= ST_CODE_BUSY;
        end else if (trig_take) begin
            status_q <= ST_CODE_BUSY;
        end else if (fin_abort) begin
            status_q <= ST_CODE_ABORT;
        end else if (fin_ok) begin
            status_q <= ST_CODE_OK;
        end
    end

    assign count_ext = 8'(count_q);

    always_comb begin
        unique case (reg_addr)
            A_COUNT:  rd_data = count_ext;
            A_STATUS: rd_data = status_q;
            default:  rd_data = 8'h00;
        endcase
    end

    p_busy_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trig_take |=> status_q == ST_CODE_BUSY);
    p_abort_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fin_abort |=> status_q == ST_CODE_ABORT);
    p_ok_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fin_ok |=> status_q == ST_CODE_OK);
endmodule

// File: rtl/cbm_beat_ctr.sv
module cbm_beat_ctr #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] beat_num,
    output logic             last
);
    logic [CNT_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (load) begin
            idx_q <= '0;
        end else if (run) begin
            idx_q <= idx_q + CNT_W'(1);
        end
    end

    assign beat_num = idx_q;
    assign last     = run && (idx_q == count - CNT_W'(1));

    p_beat_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> beat_num < count);
    p_beat_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> beat_num == $past(beat_num) + CNT_W'(1));
endmodule

// File: rtl/cbm_fsm.sv
module cbm_fsm
    import cbm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic svc_req,
    input  logic trig_wr,
    input  logic status_rd,
    input  logic cpu_sync,
    input  logic cpu_vp_n,
    input  logic host_reset,
    input  logic count_zero,
    input  logic last_beat,
    output logic irq_n,
    output logic rdy,
    output logic be,
    output logic beat_run,
    output logic start_master,
    output logic trig_take,
    output logic fin_ok,
    output logic fin_abort
);
    cbm_state_e state_q, state_d;
    logic abort_ev;

    assign abort_ev = !cpu_vp_n || host_reset;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (svc_req) state_d = ST_REQ_IRQ;
            ST_REQ_IRQ:   if (trig_wr) state_d = ST_ARMED;
            ST_ARMED:     if (abort_ev || count_zero) state_d = ST_DONE;
                          else state_d = ST_WAIT_SYNC;
            ST_WAIT_SYNC: if (abort_ev) state_d = ST_DONE;
                          else if (cpu_sync) state_d = ST_MASTER;
            ST_MASTER:    if (last_beat) state_d = ST_RELEASE;
            ST_RELEASE:   state_d = ST_DONE;
            ST_DONE:      if (status_rd) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        irq_n        = (state_q != ST_REQ_IRQ);
        be           = (state_q != ST_MASTER);
        rdy          = !(state_q == ST_MASTER || state_q == ST_RELEASE);
        beat_run     = (state_q == ST_MASTER);
        trig_take    = (state_q == ST_REQ_IRQ) && trig_wr;
        start_master = (state_q == ST_WAIT_SYNC) && !abort_ev && cpu_sync;
        fin_abort    = (state_q == ST_ARMED || state_q == ST_WAIT_SYNC) && abort_ev;
        fin_ok       = (state_q == ST_RELEASE) ||
                       (state_q == ST_ARMED && !abort_ev && count_zero);
    end

    p_irq_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && trig_wr) |=> irq_n);
    p_take_on_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(be) |-> ($past(cpu_sync) && $past(cpu_vp_n) && !$past(host_reset)));
    p_be_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> ($past(be) && be));
    p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fin_abort |=> (be && rdy));
endmodule

// File: rtl/card_busmaster_ctl.sv
module card_busmaster_ctl
    import cbm_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             svc_req,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             cpu_sync,
    input  logic             cpu_vp_n,
    input  logic             host_reset,
    output logic             irq_n,
    output logic             rdy,
    output logic             be,
    output logic             xfer_beat,
    output logic [CNT_W-1:0] beat_num
);
    logic             trig_wr, trig_take, fin_ok, fin_abort;
    logic             start_master, beat_run, last_beat, status_rd;
    logic [CNT_W-1:0] count_q;
    logic [7:0]       status_q;

    assign status_rd = reg_rd && (reg_addr == A_STATUS);

    cbm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .trig_take(trig_take), .fin_ok(fin_ok),
        .fin_abort(fin_abort), .trig_wr(trig_wr), .count_q(count_q),
        .status_q(status_q), .rd_data(reg_rdata)
    );

    cbm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .svc_req(svc_req), .trig_wr(trig_wr),
        .status_rd(status_rd), .cpu_sync(cpu_sync), .cpu_vp_n(cpu_vp_n),
        .host_reset(host_reset), .count_zero(count_q == '0),
        .last_beat(last_beat), .irq_n(irq_n), .rdy(rdy), .be(be),
        .beat_run(beat_run), .start_master(start_master),
        .trig_take(trig_take), .fin_ok(fin_ok), .fin_abort(fin_abort)
    );

    cbm_beat_ctr #(.CNT_W(CNT_W)) u_beats (
        .clk(clk), .rst_n(rst_n), .load(start_master), .run(beat_run),
        .count(count_q), .beat_num(beat_num), .last(last_beat)
    );

    assign xfer_beat = beat_run;

    p_idle_trigger_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n && rdy && be && trig_wr && status_q != ST_CODE_BUSY) |=> $stable(status_q));
endmodule

// File: tb/tb_card_busmaster_ctl.sv
`timescale 1ns/100ps
module tb_card_busmaster_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       svc_req = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd2;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       cpu_sync = 1'b0, cpu_vp_n = 1'b1, host_reset = 1'b0;
    logic       irq_n, rdy, be, xfer_beat;
    logic [7:0] beat_num;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    card_busmaster_ctl dut (
        .clk(clk), .rst_n(rst_n), .svc_req(svc_req), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cpu_sync(cpu_sync), .cpu_vp_n(cpu_vp_n),
        .host_reset(host_reset), .irq_n(irq_n), .rdy(rdy), .be(be),
        .xfer_beat(xfer_beat), .beat_num(beat_num)
    );

    // {count, sync delay, kind, expected status}
    // kind: 0 sync, 1 vector pull, 2 host reset, 3 vector pull with sync, 4 sync also in ARMED
    localparam logic [31:0] VEC [9] = '{
        {8'd3,   8'd1, 8'd0, 8'h01},
        {8'd1,   8'd4, 8'd0, 8'h01},
        {8'd0,   8'd1, 8'd0, 8'h01},
        {8'd200, 8'd2, 8'd0, 8'h01},
        {8'd2,   8'd2, 8'd4, 8'h01},
        {8'd5,   8'd0, 8'd1, 8'h80},
        {8'd5,   8'd3, 8'd1, 8'h80},
        {8'd7,   8'd2, 8'd2, 8'h80},
        {8'd4,   8'd2, 8'd3, 8'h80}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic run_txn(input int cnt, input int dly, input int kind, input int expst);
        int beats, rdylow, wait_n;
        bit prev_be, prev_rdy;
        reg_addr = 2'd0; reg_wdata = 8'(cnt); reg_wr = 1'b1; step();
        reg_wr = 1'b0; reg_addr = 2'd2;
        svc_req = 1'b1; step();
        chk(irq_n == 1'b0, "R2 irq asserted", irq_n, 0);
        svc_req = 1'b0; reg_addr = 2'd1; reg_wr = 1'b1; step();
        reg_wr = 1'b0; reg_addr = 2'd2;
        chk(irq_n == 1'b1, "R4 irq dropped", irq_n, 1);
        chk(reg_rdata == 8'h00, "R4 busy status", reg_rdata, 0);
        wait_n = dly;
        if (kind == 4) begin
            cpu_sync = 1'b1; step(); cpu_sync = 1'b0;
            chk(be == 1'b1, "R5 sync in ARMED ignored", be, 1);
            wait_n = dly - 1;
        end
        for (int k = 0; k < wait_n; k++) begin
            step();
            chk(be == 1'b1 && rdy == 1'b1, "R5 bus held until sync", be, 1);
        end
        if (kind == 0 || kind == 4 || kind == 3) cpu_sync = 1'b1;
        if (kind == 1 || kind == 3) cpu_vp_n = 1'b0;
        if (kind == 2) host_reset = 1'b1;
        step();
        cpu_sync = 1'b0; cpu_vp_n = 1'b1; host_reset = 1'b0;
        beats = 0; rdylow = 0; prev_be = 1'b1; prev_rdy = 1'b0;
        for (int k = 0; k < 400; k++) begin
            if (!rdy) rdylow++;
            if (!be) begin
                chk(xfer_beat && beat_num == 8'(beats) && !rdy, "R6 beat index", beat_num, beats);
                beats++;
            end
            if (rdy && !prev_rdy && k > 0) chk(prev_be, "R7 be before rdy", prev_be, 1);
            if (reg_rdata != 8'h00) break;
            prev_be = be; prev_rdy = rdy;
            step();
        end
        if (expst == 8'h80) chk(reg_rdata == 8'(expst), "R8 abort status", reg_rdata, expst);
        else if (cnt == 0)  chk(reg_rdata == 8'(expst), "R10 zero count status", reg_rdata, expst);
        else                chk(reg_rdata == 8'(expst), "R9 success status", reg_rdata, expst);
        chk(beats == ((expst == 8'h01) ? cnt : 0), "R6 R8 beat count", beats, (expst == 8'h01) ? cnt : 0);
        chk(rdylow == ((expst == 8'h01 && cnt > 0) ? cnt + 1 : 0), "R7 R10 rdy low cycles",
            rdylow, (expst == 8'h01 && cnt > 0) ? cnt + 1 : 0);
        chk(rdy && be, "R9 bus returned in DONE", {rdy, be}, 3);
        reg_rd = 1'b1; step(); reg_rd = 1'b0; step();
        chk(reg_rdata == 8'(expst), "R11 status holds after read", reg_rdata, expst);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(); step();
        chk(irq_n && rdy && be, "R1 reset outputs", {irq_n, rdy, be}, 7);
        chk(reg_rdata == 8'h00, "R1 reset status", reg_rdata, 0);
        reg_addr = 2'd0; #0.1;
        chk(reg_rdata == 8'h00, "R1 reset count", reg_rdata, 0);
        rst_n = 1'b1; step();
        reg_wdata = 8'h5A; reg_wr = 1'b1; step(); reg_wr = 1'b0;
        chk(reg_rdata == 8'h5A, "R3 count readback", reg_rdata, 8'h5A);
        reg_addr = 2'd1; reg_wr = 1'b1; step(); reg_wr = 1'b0; reg_addr = 2'd2;
        for (int k = 0; k < 3; k++) begin
            cpu_sync = 1'b1; step(); cpu_sync = 1'b0;
            chk(irq_n && rdy && be, "R12 idle trigger ignored", {irq_n, rdy, be}, 7);
        end
        chk(reg_rdata == 8'h00, "R12 status unchanged", reg_rdata, 0);
        foreach (VEC[i]) begin
            run_txn(int'(VEC[i][31:24]), int'(VEC[i][23:16]), int'(VEC[i][15:8]), int'(VEC[i][7:0]));
        end
        svc_req = 1'b1; step(); svc_req = 1'b0;
        chk(irq_n == 1'b0, "R11 new request after acknowledge", irq_n, 0);
        chk(reg_rdata == 8'h80, "R11 status held until trigger", reg_rdata, 8'h80);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule